// File: doc/BRIEF.md
# Paged Code Fetch Translation Unit

This block turns a virtual instruction-fetch address into a physical code-memory address. It keeps a small, fully associative page table, with one entry for each 256-byte physical page. Each entry holds a valid bit, a virtual page tag taken from address bits 31:8, and two flags: busy and usable. The fetch side is combinational and works on the table as it stands in the current cycle. For each fetch it reports exactly one outcome: a completed translation, a stall, or a fault with a four-bit cause code.

A host loads code through an upload port. The port carries a physical word address and the virtual address that the page should answer to. The block does not store the code words. It only watches the word offset within the page to track the page's life cycle:

- The first word of a page maps the page's entry to the new virtual page and marks it busy.
- The last word of a page marks it usable.

A fetch that lands on a page still being loaded waits instead of faulting. A fetch that matches no entry, or more than one entry, raises a fault whose cause code the surrounding trap logic can latch directly.

Top module: `code_page_xlat`

## Requirements
- R1: After reset every entry is invalid, so any fetch reports a fault with cause 0xA.
- R2: An upload whose physical address bits 7:2 are all zero sets the entry named by the address bits above bit 7 to valid. It stores upload virtual bits 31:8 as that entry's tag and sets the entry busy and not usable. A fetch that hits that entry alone then stalls (stall=1, done=0, fault=0).
- R3: An upload whose physical address bits 7:2 are neither all zero nor all ones leaves the entry's tag and flags unchanged. A stalled fetch therefore stays stalled.
- R4: An upload whose physical address bits 7:2 are all ones clears the entry's busy flag and sets its usable flag. A fetch that hits that entry alone then completes (done=1).
- R5: On a completed fetch the physical address equals the hit entry index shifted left by 8, ORed with fetch virtual bits 7:0. It is zero whenever done is low.
- R6: A fetch whose bits 31:8 match no valid entry gives fault=1 with cause 0xA.
- R7: A fetch whose bits 31:8 match two or more valid entries gives fault=1 with cause 0xB, whatever the flags of those entries.
- R8: Mapping a page again with a first-word upload replaces its tag. The old virtual page no longer hits it, and the new virtual page stalls until its last word is uploaded.
- R9: While fetch_valid is high exactly one of done, stall and fault is high. While it is low all three are low, and the cause and address outputs are zero.
- R10: An upload takes effect on the next clock edge. A fetch in the same cycle as the upload sees the table as it was before that upload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upl_valid | input | 1 | Upload word strobe |
| upl_paddr | input | PA_W (11) | Physical byte address of the uploaded word |
| upl_vaddr | input | 32 | Virtual address the page is mapped to |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_vaddr | input | 32 | Virtual fetch address |
| fetch_done | output | 1 | Translation completed this cycle |
| fetch_stall | output | 1 | Hit page still loading |
| fetch_fault | output | 1 | Translation fault |
| fault_cause | output | 4 | 0xA no hit, 0xB multiple hits, else 0 |
| fetch_paddr | output | PA_W (11) | Physical code address |

## Verification
A corrupted tag or valid bit shows up at the ports on the very next fetch to the affected virtual page. It appears as a fault where a translation was expected, or as a wrong upper field in the physical address. A stuck busy or usable flag shows as a stall that never clears after the last-word upload, or as a fetch that completes too early during the load. Because lookup is combinational, every such error is visible in the first cycle after the upload edge that should have changed the entry. A wrong hit count shows as the wrong cause code, on the first fetch to a tag that is shared by two entries.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int VA_W      = 32;
   localparam int PG_BITS   = 8;
   localparam int TAG_W     = VA_W - PG_BITS;
   localparam logic [3:0] CAUSE_NONE  = 4'h0;
   localparam logic [3:0] CAUSE_NOHIT = 4'hA;
   localparam logic [3:0] CAUSE_MULTI = 4'hB;

   typedef struct packed {
      logic             valid;
      logic [TAG_W-1:0] tag;
      logic             busy;
      logic             usable;
   } page_ent_t;
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
   import xlat_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_first,
   input  logic             wr_last,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit,
   output logic             busy,
   output logic             usable
);
   page_ent_t ent_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q <= '0;
      end else if (wr_first) begin
         ent_q.valid  <= 1'b1;
         ent_q.tag    <= wr_tag;
         ent_q.busy   <= 1'b1;
         ent_q.usable <= 1'b0;
      end else if (wr_last) begin
         ent_q.busy   <= 1'b0;
         ent_q.usable <= 1'b1;
      end
   end

   assign hit    = ent_q.valid && (ent_q.tag == look_tag);
   assign busy   = ent_q.busy;
   assign usable = ent_q.usable;

   // R2
   map_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_first |=> (busy && !usable && ent_q.tag == $past(wr_tag)));
   // R4
   load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_last && !wr_first) |=> (usable && !busy));
endmodule

// File: rtl/xlat_match_enc.sv
module xlat_match_enc #(
   parameter int NPAGES = 8,
   localparam int IDX_W = $clog2(NPAGES),
   localparam int CNT_W = $clog2(NPAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPAGES-1:0] hit_vec,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [CNT_W-1:0]  hit_cnt
);
   always_comb begin
      hit_idx = '0;
      for (int i = NPAGES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

   always_comb begin
      hit_cnt = '0;
      for (int i = 0; i < NPAGES; i++) begin
         hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
      end
   end

   // R5
   idx_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cnt == CNT_W'(1)) |-> hit_vec[hit_idx]);
   // R7
   cnt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cnt > CNT_W'(1)) |-> !$onehot0(hit_vec));
endmodule

// File: rtl/code_page_xlat.sv
module code_page_xlat
   import xlat_pkg::*;
#(
   parameter int NPAGES = 8,
   localparam int IDX_W = $clog2(NPAGES),
   localparam int PA_W  = IDX_W + PG_BITS,
   localparam int CNT_W = $clog2(NPAGES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upl_valid,
   input  logic [PA_W-1:0] upl_paddr,
   input  logic [VA_W-1:0] upl_vaddr,
   input  logic            fetch_valid,
   input  logic [VA_W-1:0] fetch_vaddr,
   output logic            fetch_done,
   output logic            fetch_stall,
   output logic            fetch_fault,
   output logic [3:0]      fault_cause,
   output logic [PA_W-1:0] fetch_paddr
);
   localparam int WOFF_W = PG_BITS - 2;

   generate
      if (NPAGES < 2) begin : g_bad_pages
         $error("code_page_xlat: NPAGES must be at least 2");
      end
   endgenerate

   logic [WOFF_W-1:0] upl_woff;
   logic [IDX_W-1:0]  upl_page;
   logic              is_first, is_last;
   logic [NPAGES-1:0] hit_vec, busy_vec, usable_vec;
   logic [IDX_W-1:0]  hit_idx;
   logic [CNT_W-1:0]  hit_cnt;

   assign upl_woff = upl_paddr[PG_BITS-1:2];
   assign upl_page = upl_paddr[PA_W-1:PG_BITS];
   assign is_first = upl_valid && (upl_woff == '0);
   assign is_last  = upl_valid && (upl_woff == '1);

   for (genvar g = 0; g < NPAGES; g++) begin : g_page
      logic sel;
      assign sel = (upl_page == IDX_W'(g));
      xlat_entry u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_first (is_first && sel),
         .wr_last  (is_last && sel),
         .wr_tag   (upl_vaddr[VA_W-1:PG_BITS]),
         .look_tag (fetch_vaddr[VA_W-1:PG_BITS]),
         .hit      (hit_vec[g]),
         .busy     (busy_vec[g]),
         .usable   (usable_vec[g])
      );
   end

   xlat_match_enc #(.NPAGES(NPAGES)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_vec (hit_vec),
      .hit_idx (hit_idx),
      .hit_cnt (hit_cnt)
   );

   always_comb begin
      fetch_done  = 1'b0;
      fetch_stall = 1'b0;
      fetch_fault = 1'b0;
      fault_cause = CAUSE_NONE;
      fetch_paddr = '0;
      if (fetch_valid) begin
         if (hit_cnt == '0) begin
            fetch_fault = 1'b1;
            fault_cause = CAUSE_NOHIT;
         end else if (hit_cnt != CNT_W'(1)) begin
            fetch_fault = 1'b1;
            fault_cause = CAUSE_MULTI;
         end else if (usable_vec[hit_idx]) begin
            fetch_done  = 1'b1;
            fetch_paddr = {hit_idx, fetch_vaddr[PG_BITS-1:0]};
         end else begin
            fetch_stall = 1'b1;
         end
      end
   end

   // R9
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> ($countones({fetch_done, fetch_stall, fetch_fault}) == 1));
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> (!fetch_done && !fetch_stall && !fetch_fault && fault_cause == 4'h0));
   // R5
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |-> (fetch_paddr[PG_BITS-1:0] == fetch_vaddr[PG_BITS-1:0]));
   // R4
   stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> busy_vec[hit_idx]);
endmodule

// File: tb/code_page_xlat_tb.sv
module code_page_xlat_tb;
   localparam int NP    = 8;
   localparam int IDX_W = $clog2(NP);
   localparam int PA_W  = IDX_W + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upl_valid = 1'b0;
   logic [PA_W-1:0] upl_paddr = '0;
   logic [31:0] upl_vaddr = '0;
   logic fetch_valid = 1'b0;
   logic [31:0] fetch_vaddr = '0;
   logic fetch_done, fetch_stall, fetch_fault;
   logic [3:0] fault_cause;
   logic [PA_W-1:0] fetch_paddr;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   bit m_valid [NP];
   logic [23:0] m_tag [NP];
   bit m_busy [NP];
   bit m_usable [NP];

   always #4 clk = ~clk;

   code_page_xlat #(.NPAGES(NP)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .upl_valid(upl_valid), .upl_paddr(upl_paddr), .upl_vaddr(upl_vaddr),
      .fetch_valid(fetch_valid), .fetch_vaddr(fetch_vaddr),
      .fetch_done(fetch_done), .fetch_stall(fetch_stall), .fetch_fault(fetch_fault),
      .fault_cause(fault_cause), .fetch_paddr(fetch_paddr)
   );

   function automatic logic [19:0] expect_out(input bit fv, input logic [31:0] va);
      int n = 0;
      int idx = 0;
      logic [19:0] r = '0;
      if (!fv) return r;
      for (int i = 0; i < NP; i++) begin
         if (m_valid[i] && m_tag[i] == va[31:8]) begin
            if (n == 0) idx = i;
            n++;
         end
      end
      if (n == 0)       r = {1'b0, 1'b0, 1'b1, 4'hA, 13'd0};
      else if (n > 1)   r = {1'b0, 1'b0, 1'b1, 4'hB, 13'd0};
      else if (m_usable[idx]) r = {1'b1, 1'b0, 1'b0, 4'h0, 2'b0, IDX_W'(idx), va[7:0]};
      else              r = {1'b0, 1'b1, 1'b0, 4'h0, 13'd0};
      return r;
   endfunction

   task automatic check(input string req, input bit fv, input logic [31:0] va);
      logic [19:0] e, a;
      e = expect_out(fv, va);
      a = {fetch_done, fetch_stall, fetch_fault, fault_cause, 2'b0, fetch_paddr};
      checks++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h (va=%h)", req, a, e, va);
      end
   endtask

   task automatic cyc(input string req, input bit uv, input logic [PA_W-1:0] up,
                      input logic [31:0] uva, input bit fv, input logic [31:0] fva);
      int pg;
      upl_valid = uv; upl_paddr = up; upl_vaddr = uva;
      fetch_valid = fv; fetch_vaddr = fva;
      #1;
      check(req, fv, fva);
      @(posedge clk);
      if (uv) begin
         pg = int'(up[PA_W-1:8]);
         if (up[7:2] == 6'h00) begin
            m_valid[pg] = 1; m_tag[pg] = uva[31:8]; m_busy[pg] = 1; m_usable[pg] = 0;
         end else if (up[7:2] == 6'h3F) begin
            m_busy[pg] = 0; m_usable[pg] = 1;
         end
      end
      @(negedge clk);
   endtask

   function automatic logic [PA_W-1:0] pa(input int pg, input int woff);
      return {IDX_W'(pg), 6'(woff), 2'b00};
   endfunction

   initial begin
      for (int i = 0; i < NP; i++) begin
         m_valid[i] = 0; m_tag[i] = '0; m_busy[i] = 0; m_usable[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty table faults with no-hit
      cyc("R1", 0, '0, '0, 1, 32'h0000_1234);
      // R9: idle outputs quiet
      cyc("R9", 0, '0, '0, 0, 32'h0000_1234);
      // R10: first-word upload and fetch same cycle sees old table
      cyc("R10", 1, pa(3, 0), 32'h0004_5600, 1, 32'h0004_5610);
      // R2: now stalls
      cyc("R2", 0, '0, '0, 1, 32'h0004_5610);
      // R3: middle word keeps stall
      cyc("R3", 1, pa(3, 17), 32'h0, 1, 32'h0004_56AB);
      cyc("R3", 0, '0, '0, 1, 32'h0004_56AB);
      // R4: last word makes usable
      cyc("R4", 1, pa(3, 63), 32'h0, 1, 32'h0004_56FF);
      // R5: physical address composition
      cyc("R5", 0, '0, '0, 1, 32'h0004_56C7);
      // R6: other tag misses
      cyc("R6", 0, '0, '0, 1, 32'h0004_5700);
      // R7: second page with same tag
      cyc("R7", 1, pa(6, 0), 32'h0004_5600, 0, '0);
      cyc("R7", 0, '0, '0, 1, 32'h0004_5604);
      // R8: remap page 3 away, page 6 alone stalls; old tag gone after remap of 6
      cyc("R8", 1, pa(3, 0), 32'h0009_0000, 1, 32'h0004_5604);
      cyc("R8", 0, '0, '0, 1, 32'h0004_5604);
      cyc("R8", 1, pa(6, 0), 32'h000A_0000, 1, 32'h0009_0010);
      cyc("R8", 0, '0, '0, 1, 32'h0004_5604);
      // Random phase with small tag pool
      void'($urandom(32'd1357));
      for (int k = 0; k < 3000; k++) begin
         int sel, pg, woff;
         logic [31:0] uva, fva;
         sel = int'($urandom_range(0, 3));
         pg = int'($urandom_range(0, NP - 1));
         woff = (sel == 0) ? 0 : (sel == 1) ? 63 : int'($urandom_range(1, 62));
         uva = {22'd0, 2'($urandom_range(0, 3)), 8'($urandom)};
         fva = {22'd0, 2'($urandom_range(0, 3)), 8'($urandom)};
         cyc("R4/R5/R6/R7", ($urandom_range(0, 2) != 0), pa(pg, woff), uva,
             ($urandom_range(0, 5) != 0), fva);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule